// File: doc/BRIEF.md
# Input-Window Power-Path Sequencer

This block is the digital controller for a load switch that sits between an input supply and downstream circuitry. Each clock it receives a sampled input voltage as an unsigned millivolt code. Two hysteresis comparators decide whether that voltage lies inside a safe window, bounded by an under-voltage limit and an over-voltage limit. A state machine then sequences the switch and a fault flag.

After the input enters the window, a startup qualification delay must pass before the switch closes. A second delay of the same length must then pass before the fault flag is released. The flag is an open-drain enable: an output of 1 means the line is pulled low, which signals a fault or a supply that is not yet qualified. The shutdown input holds the switch open, but it does not stop qualification, so the flag keeps reporting the state of the input. Any excursion out of the window opens the switch, pulls the flag and restarts qualification from zero, whatever the shutdown level.

Top module: `pwr_window_seq`

## Requirements
- R1: `sw_on` is 1 only while the input is inside the window and `shdn` is 0.
- R2: With `shdn` at 0, `sw_on` rises DELAY_CYC+2 cycles after the clock edge that first samples an in-window code. This is one cycle for the comparator, one to leave the fault state, then DELAY_CYC cycles of qualification.
- R3: An out-of-window code sampled on edge k gives `sw_on`=0 and `flag_pull`=1 right after edge k, in any phase. On re-entry, both timers restart from zero.
- R4: `flag_pull` falls to 0 exactly DELAY_CYC cycles after the cycle in which the output was connected (or would have been connected, if shutdown held it open).
- R5: While `shdn` is 1, `sw_on` stays 0, but `flag_pull` still falls after the same 2·DELAY_CYC+2 cycles when the input is in the window.
- R6: A fault pulls the flag and keeps the switch open even when `shdn` is 1. Shutdown never masks a fault.
- R7: The under-voltage condition sets when the input is below UV_MV (default 3250) and clears only when it is above UV_MV+UV_HYS (default 3300).
- R8: The over-voltage condition sets when the input is above OV_MV (default 6400) and clears only when it is below OV_MV−OV_HYS (default 6300).
- R9: Once the input is fully qualified, `sw_on` follows the inverse of `shdn` in the same cycle, and `flag_pull` stays 0.
- R10: Synchronous reset gives `sw_on`=0 and `flag_pull`=1, with the sequencer in its fault state and the timer cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_mv | input | VIN_W | Sampled input voltage, unsigned millivolts |
| shdn | input | 1 | Active-high shutdown; holds the switch open |
| sw_on | output | 1 | 1 closes the power switch |
| flag_pull | output | 1 | Open-drain enable; 1 pulls the fault line low |

## Verification
A nominal in-window code shows the exact closing cycle of the switch and the release cycle of the flag. Codes placed just inside and just outside each hysteresis band (3260, 3240, 3290, 3310 and 6400, 6401, 6350, 6299) separate the set level from the clear level of each comparator. A dip out of the window partway through qualification shows that the timer restarts rather than resumes. Runs with shutdown held high, then toggled, then combined with an over-voltage event show that the flag follows the input independently of the switch, and that a fault wins over shutdown.

// File: rtl/pws_pkg.sv
package pws_pkg;
   typedef enum logic [1:0] {
      ST_FAULT = 2'd0,
      ST_QUAL  = 2'd1,
      ST_CONN  = 2'd2,
      ST_READY = 2'd3
   } pws_state_e;
endpackage

// File: rtl/pws_hyst_cmp.sv
// Single-threshold comparator with hysteresis. HIGH_SIDE picks the variant:
// 1 = trips above THR and recovers below THR-HYS, 0 = trips below THR and
// recovers above THR+HYS.
module pws_hyst_cmp #(
   parameter int VIN_W     = 16,
   parameter int THR       = 3250,
   parameter int HYS       = 50,
   parameter bit HIGH_SIDE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [VIN_W-1:0] vin,
   output logic             trip
);
   localparam logic [VIN_W-1:0] THR_V = VIN_W'(THR);

   initial assert (THR + HYS < (1 << VIN_W) && THR >= HYS && HYS >= 0)
      else $error("pws_hyst_cmp: threshold/hysteresis do not fit VIN_W");

   logic trip_q;
   assign trip = trip_q;

   generate
      if (HIGH_SIDE) begin : g_high
         localparam logic [VIN_W-1:0] REL_V = VIN_W'(THR - HYS);
         always_ff @(posedge clk) begin
            if (rst)                        trip_q <= 1'b0;
            else if (!trip_q && vin > THR_V) trip_q <= 1'b1;
            else if (trip_q && vin < REL_V)  trip_q <= 1'b0;
         end
         assert_ov_set_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(trip_q) |-> $past(vin) > THR_V);
         assert_ov_clear_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(trip_q) |-> $past(vin) < REL_V);
      end else begin : g_low
         localparam logic [VIN_W-1:0] REL_V = VIN_W'(THR + HYS);
         always_ff @(posedge clk) begin
            if (rst)                        trip_q <= 1'b1;
            else if (trip_q && vin > REL_V)  trip_q <= 1'b0;
            else if (!trip_q && vin < THR_V) trip_q <= 1'b1;
         end
         assert_uv_clear_R7: assert property (@(posedge clk) disable iff (rst)
            $fell(trip_q) |-> $past(vin) > REL_V);
         assert_uv_set_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(trip_q) |-> $past(vin) < THR_V);
      end
   endgenerate
endmodule

// File: rtl/pws_timer.sv
// Shared saturating qualification counter.
module pws_timer #(
   parameter int DELAY_CYC = 6_250_000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic done
);
   localparam int             CW   = (DELAY_CYC > 2) ? $clog2(DELAY_CYC) : 1;
   localparam logic [CW-1:0]  LAST = CW'(DELAY_CYC - 1);

   initial assert (DELAY_CYC >= 2)
      else $error("pws_timer: DELAY_CYC must be at least 2");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr)              cnt <= '0;
      else if (en && cnt != LAST)  cnt <= cnt + CW'(1);
   end

   assign done = (cnt == LAST);

   assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);
   assert_cnt_saturates_R2: assert property (@(posedge clk) disable iff (rst)
      (done && en && !clr) |=> done);
endmodule

// File: rtl/pws_fsm.sv
// Sequencer: fault -> startup qualification -> connected (flag pending) -> ready.
module pws_fsm
   import pws_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       in_win,
   input  logic       tmr_done,
   output pws_state_e state,
   output logic       tmr_clr,
   output logic       tmr_en
);
   pws_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_FAULT: if (in_win)        st_d = ST_QUAL;
         ST_QUAL:  if (!in_win)       st_d = ST_FAULT;
                   else if (tmr_done) st_d = ST_CONN;
         ST_CONN:  if (!in_win)       st_d = ST_FAULT;
                   else if (tmr_done) st_d = ST_READY;
         ST_READY: if (!in_win)       st_d = ST_FAULT;
         default:                     st_d = ST_FAULT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_FAULT;
      else     st_q <= st_d;
   end

   assign state   = st_q;
   assign tmr_clr = (st_d != st_q) || (st_q == ST_FAULT) || (st_q == ST_READY);
   assign tmr_en  = !tmr_clr;

   assert_fault_resets_R3: assert property (@(posedge clk) disable iff (rst)
      !in_win |=> st_q == ST_FAULT);
   assert_conn_after_qual_R2: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_CONN && $past(st_q) != ST_CONN) |-> $past(st_q) == ST_QUAL);
   assert_ready_after_conn_R4: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_READY && $past(st_q) != ST_READY) |-> $past(st_q) == ST_CONN);
endmodule

// File: rtl/pwr_window_seq.sv
module pwr_window_seq
   import pws_pkg::*;
#(
   parameter int VIN_W     = 16,
   parameter int UV_MV     = 3250,
   parameter int UV_HYS    = 50,
   parameter int OV_MV     = 6400,
   parameter int OV_HYS    = 100,
   parameter int DELAY_CYC = 6_250_000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [VIN_W-1:0] vin_mv,
   input  logic             shdn,
   output logic             sw_on,
   output logic             flag_pull
);
   initial assert (OV_MV - OV_HYS > UV_MV + UV_HYS)
      else $error("pwr_window_seq: window bands overlap");

   logic       uv_trip, ov_trip, in_win;
   logic       tmr_clr, tmr_en, tmr_done;
   pws_state_e state;

   pws_hyst_cmp #(.VIN_W(VIN_W), .THR(UV_MV), .HYS(UV_HYS), .HIGH_SIDE(1'b0))
      u_uv (.clk(clk), .rst(rst), .vin(vin_mv), .trip(uv_trip));

   pws_hyst_cmp #(.VIN_W(VIN_W), .THR(OV_MV), .HYS(OV_HYS), .HIGH_SIDE(1'b1))
      u_ov (.clk(clk), .rst(rst), .vin(vin_mv), .trip(ov_trip));

   assign in_win = !uv_trip && !ov_trip;

   pws_timer #(.DELAY_CYC(DELAY_CYC))
      u_tmr (.clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en), .done(tmr_done));

   pws_fsm u_fsm (
      .clk(clk), .rst(rst), .in_win(in_win), .tmr_done(tmr_done),
      .state(state), .tmr_clr(tmr_clr), .tmr_en(tmr_en)
   );

   // Window gating makes a fault open the switch in the cycle it is registered.
   assign sw_on     = in_win && !shdn && (state == ST_CONN || state == ST_READY);
   assign flag_pull = !(in_win && state == ST_READY);

   assert_sw_window_R1: assert property (@(posedge clk) disable iff (rst)
      sw_on |-> (!shdn && !uv_trip && !ov_trip));
   assert_fault_wins_R6: assert property (@(posedge clk) disable iff (rst)
      (uv_trip || ov_trip) |-> (!sw_on && flag_pull));
   assert_flag_state_R4: assert property (@(posedge clk) disable iff (rst)
      !flag_pull |-> state == ST_READY);
endmodule

// File: tb/pwr_window_seq_test.sv
module pwr_window_seq_test;
   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] vin_mv = '0;
   logic        shdn = 1'b0;
   logic        sw_on, flag_pull;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      int    at;
      logic  sw;
      logic  pull;
      string tag;
   } exp_t;
   exp_t sbq[$];

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   pwr_window_seq #(.DELAY_CYC(D)) uut (
      .clk(clk), .rst(rst), .vin_mv(vin_mv), .shdn(shdn),
      .sw_on(sw_on), .flag_pull(flag_pull)
   );

   // Driver side: schedule an expected output pair for a future cycle.
   task automatic expect_at(int at, logic s, logic p, string tag);
      exp_t e;
      int   i = 0;
      e.at = at; e.sw = s; e.pull = p; e.tag = tag;
      while (i < sbq.size() && sbq[i].at <= at) i++;
      sbq.insert(i, e);
   endtask

   // Monitor: compare every due item away from the rising edge.
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
         exp_t e;
         e = sbq.pop_front();
         n_chk++;
         if (e.at != cyc || sw_on !== e.sw || flag_pull !== e.pull) begin
            n_bad++;
            $display("FAIL %s cyc %0d: sw_on=%b flag_pull=%b expected sw_on=%b flag_pull=%b",
                     e.tag, cyc, sw_on, flag_pull, e.sw, e.pull);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic drive(int mv);
      vin_mv = 16'(mv);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int c;
      tick(1);
      expect_at(cyc + 1, 1'b0, 1'b1, "R10");          // reset state
      tick(3);
      rst = 1'b0;
      tick(2);

      // Nominal qualification
      c = cyc; drive(5000);
      expect_at(c + 1 + D,   1'b0, 1'b1, "R2");
      expect_at(c + 2 + D,   1'b1, 1'b1, "R2");
      expect_at(c + 2 + D,   1'b1, 1'b1, "R1");
      expect_at(c + 1 + 2*D, 1'b1, 1'b1, "R4");
      expect_at(c + 2 + 2*D, 1'b1, 0,    "R4");
      tick(2*D + 4);

      // Under-voltage hysteresis
      c = cyc; drive(3260);
      expect_at(c + 3, 1'b1, 1'b0, "R7");
      tick(4);
      c = cyc; drive(3240);
      expect_at(c + 1, 1'b0, 1'b1, "R7");
      expect_at(c + 1, 1'b0, 1'b1, "R1");
      tick(3);
      c = cyc; drive(3290);
      expect_at(c + 3 + 2*D, 1'b0, 1'b1, "R7");
      tick(2*D + 5);
      c = cyc; drive(3310);
      expect_at(c + 2 + D,   1'b1, 1'b1, "R7");
      expect_at(c + 2 + 2*D, 1'b1, 1'b0, "R7");
      tick(2*D + 4);

      // Over-voltage hysteresis
      c = cyc; drive(6400);
      expect_at(c + 3, 1'b1, 1'b0, "R8");
      tick(4);
      c = cyc; drive(6401);
      expect_at(c + 1, 1'b0, 1'b1, "R8");
      tick(3);
      c = cyc; drive(6350);
      expect_at(c + 3 + 2*D, 1'b0, 1'b1, "R8");
      tick(2*D + 5);
      c = cyc; drive(6299);
      expect_at(c + 2 + D,   1'b1, 1'b1, "R8");
      expect_at(c + 2 + 2*D, 1'b1, 1'b0, "R8");
      tick(2*D + 4);

      // Dip during qualification restarts the timer; fault while connected
      drive(2000); tick(3);
      drive(5000); tick(5);
      drive(2000); tick(3);
      c = cyc; drive(5000);
      expect_at(c + 1 + D, 1'b0, 1'b1, "R3");
      expect_at(c + 2 + D, 1'b1, 1'b1, "R3");
      tick(D + 5);
      c = cyc; drive(7000);
      expect_at(c + 1, 1'b0, 1'b1, "R3");
      tick(3);

      // Shutdown during qualification
      drive(2000); tick(3);
      c = cyc; shdn = 1'b1; drive(5000);
      expect_at(c + 2 + D,   1'b0, 1'b1, "R5");
      expect_at(c + 1 + 2*D, 1'b0, 1'b1, "R5");
      expect_at(c + 2 + 2*D, 1'b0, 1'b0, "R5");
      tick(2*D + 4);
      c = cyc; shdn = 1'b0;
      expect_at(c + 1, 1'b1, 1'b0, "R9");
      tick(3);
      c = cyc; shdn = 1'b1;
      expect_at(c + 1, 1'b0, 1'b0, "R9");
      tick(3);

      // Fault while in shutdown, then requalify under shutdown
      c = cyc; drive(7000);
      expect_at(c + 1, 1'b0, 1'b1, "R6");
      tick(3);
      c = cyc; drive(5000);
      expect_at(c + 1 + 2*D, 1'b0, 1'b1, "R6");
      expect_at(c + 2 + 2*D, 1'b0, 1'b0, "R6");
      tick(2*D + 4);

      tick(2);
      if (sbq.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL R10 leftover items: %0d expected 0", sbq.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule